// File: doc/BRIEF.md
# SONET Error Event Accumulator

This block gathers per-frame error events for performance monitoring of a SONET receive path. Once per frame an upstream stage presents, under one valid strobe, the received and locally computed BIP bytes for the section, line and path layers, plus the 4-bit far-end error field taken from the path status byte. The block turns these into error-event increments and adds them into four internal saturating counters.

A snapshot, requested either by the local register write strobe or by a global load strobe shared with other blocks, copies every internal counter into a staging register and clears the counter in the same clock. The holding registers that software reads take the staged values a fixed number of cycles later, and a busy flag marks that window. Four interrupt status flags, one per counter, are set by non-zero error events when their enable is high and are cleared by a read strobe.

Top module: `sonet_err_accum`

## Requirements
- R1: In bit mode (`blk_mode` = 0) a valid frame adds to the section and path counters the number of bit positions that differ between the received and computed BIP byte.
- R2: In block mode (`blk_mode` = 1) a valid frame adds exactly one to a BIP counter when any bit of its compared bytes differs, and zero otherwise.
- R3: With `three_ch` = 1 the line comparison covers all three bytes (up to 24 per frame); with `three_ch` = 0 only bits 7:0 are compared and bits 23:8 have no effect.
- R4: The far-end field value 0 to 8 adds that many errors; values 9 to 15 add zero.
- R5: A high `snap_wr` or `snap_all` at a clock edge when not busy copies every counter to staging and clears it; an event in that same frame is counted into the new period.
- R6: Holding registers change only at the edge `XFER_LAT` (default 3) cycles after the accepted snapshot edge; `busy` is high for exactly those `XFER_LAT` cycles.
- R7: A snapshot request while `busy` is high is ignored; counting continues undisturbed.
- R8: Internal counters stop at all-ones and never wrap.
- R9: Interrupt flag k (bit 0 section, 1 line, 2 path, 3 far-end) sets one cycle after a valid frame with a non-zero increment on channel k only when `irq_en[k]` is high.
- R10: `irq_rd` clears all interrupt flags at the next edge; a flag set by an event at that same edge stays set.
- R11: After reset all holding registers, `busy` and interrupt flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_valid | input | 1 | One-cycle strobe: frame byte pairs valid |
| blk_mode | input | 1 | 1 = block counting, 0 = bit counting |
| three_ch | input | 1 | 1 = three line BIP bytes compared |
| sec_rx | input | 8 | Received section BIP byte |
| sec_calc | input | 8 | Computed section BIP byte |
| line_rx | input | 24 | Received line BIP bytes |
| line_calc | input | 24 | Computed line BIP bytes |
| path_rx | input | 8 | Received path BIP byte |
| path_calc | input | 8 | Computed path BIP byte |
| febe_fld | input | 4 | Far-end error field |
| snap_wr | input | 1 | Local snapshot request |
| snap_all | input | 1 | Global snapshot request |
| irq_en | input | 4 | Interrupt enables |
| irq_rd | input | 1 | Read strobe clearing interrupt flags |
| hold_sec | output | 16 | Section BIP holding register |
| hold_line | output | 20 | Line BIP holding register |
| hold_path | output | 16 | Path BIP holding register |
| hold_febe | output | 20 | Far-end error holding register |
| busy | output | 1 | Snapshot transfer in progress |
| irq_sts | output | 4 | Interrupt status flags |

## Verification
An increment reaches the internal counter at the edge that samples `frm_valid`, the interrupt flag is visible just after that same edge, and a snapshot accepted at edge E shows up in the holding registers only after edge E+3, with `busy` visible after E. The bench therefore drives inputs on the falling edge, lets a behavioural model advance on the rising edge, and compares every output against it on the next falling edge. Directed scenarios then wait exactly the transfer latency before checking hand-computed holding values, and check `busy`-window requests, same-cycle events and saturation at their own edges.

// File: rtl/sea_pkg.sv
package sea_pkg;
  localparam int INC_W = 5;

  function automatic logic [3:0] ones8(input logic [7:0] v);
    logic [3:0] n;
    n = '0;
    for (int i = 0; i < 8; i++) n = n + {3'd0, v[i]};
    return n;
  endfunction

  function automatic logic [3:0] febe_decode(input logic [3:0] f);
    return (f <= 4'd8) ? f : 4'd0;
  endfunction

  typedef enum logic [1:0] {CH_SEC = 2'd0, CH_LINE = 2'd1, CH_PATH = 2'd2, CH_FEBE = 2'd3} chan_e;
endpackage

// File: rtl/sea_event_calc.sv
module sea_event_calc
  import sea_pkg::*;
#(
  parameter int LINE_BYTES = 3
) (
  input  logic                    frm_valid,
  input  logic                    blk_mode,
  input  logic                    three_ch,
  input  logic [7:0]              sec_rx,
  input  logic [7:0]              sec_calc,
  input  logic [8*LINE_BYTES-1:0] line_rx,
  input  logic [8*LINE_BYTES-1:0] line_calc,
  input  logic [7:0]              path_rx,
  input  logic [7:0]              path_calc,
  input  logic [3:0]              febe_fld,
  output logic [INC_W-1:0]        inc_sec,
  output logic [INC_W-1:0]        inc_line,
  output logic [INC_W-1:0]        inc_path,
  output logic [INC_W-1:0]        inc_febe
);
  logic [7:0] sec_d, path_d;
  logic [7:0] line_d [LINE_BYTES];
  logic [INC_W-1:0] line_part [LINE_BYTES];

  assign sec_d  = sec_rx ^ sec_calc;
  assign path_d = path_rx ^ path_calc;

  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_lane
    logic lane_on;
    if (b == 0) begin : g_first
      assign lane_on = 1'b1;
    end else begin : g_rest
      assign lane_on = three_ch;
    end
    assign line_d[b]    = lane_on ? (line_rx[8*b +: 8] ^ line_calc[8*b +: 8]) : 8'd0;
    assign line_part[b] = {{(INC_W-4){1'b0}}, ones8(line_d[b])};
  end

  always_comb begin
    logic [INC_W-1:0] lsum;
    logic             lany;
    lsum = '0;
    lany = 1'b0;
    for (int b = 0; b < LINE_BYTES; b++) begin
      lsum = lsum + line_part[b];
      lany = lany | (|line_d[b]);
    end
    inc_sec  = '0;
    inc_line = '0;
    inc_path = '0;
    inc_febe = '0;
    if (frm_valid) begin
      if (blk_mode) begin
        inc_sec  = {{(INC_W-1){1'b0}}, |sec_d};
        inc_path = {{(INC_W-1){1'b0}}, |path_d};
        inc_line = {{(INC_W-1){1'b0}}, lany};
      end else begin
        inc_sec  = {{(INC_W-4){1'b0}}, ones8(sec_d)};
        inc_path = {{(INC_W-4){1'b0}}, ones8(path_d)};
        inc_line = lsum;
      end
      inc_febe = {{(INC_W-4){1'b0}}, febe_decode(febe_fld)};
    end
  end
endmodule

// File: rtl/sea_accum.sv
module sea_accum
  import sea_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [INC_W-1:0] inc,
  input  logic             take,
  input  logic             publish,
  output logic [CNT_W-1:0] hold_q
);
  localparam logic [CNT_W:0] TOP = {1'b0, {CNT_W{1'b1}}};

  logic [CNT_W-1:0] cnt_q, stage_q;
  logic [CNT_W:0]   sum, base;

  always_comb begin
    base = take ? '0 : {1'b0, cnt_q};
    sum  = base + {{(CNT_W+1-INC_W){1'b0}}, inc};
    if (sum > TOP) sum = TOP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      stage_q <= '0;
      hold_q  <= '0;
    end else begin
      cnt_q <= sum[CNT_W-1:0];
      if (take)    stage_q <= cnt_q;
      if (publish) hold_q  <= stage_q;
    end
  end
endmodule

// File: rtl/sea_xfer_ctrl.sv
module sea_xfer_ctrl #(
  parameter int XFER_LAT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic take,
  output logic publish,
  output logic busy
);
  localparam int BW = $clog2(XFER_LAT + 1);
  localparam logic [BW-1:0] LAT_V = BW'(XFER_LAT);

  logic [BW-1:0] left_q;

  assign busy    = (left_q != '0);
  assign take    = req && !busy;
  assign publish = (left_q == BW'(1));

  always_ff @(posedge clk) begin
    if (rst)       left_q <= '0;
    else if (take) left_q <= LAT_V;
    else if (busy) left_q <= left_q - BW'(1);
  end
endmodule

// File: rtl/sea_irq.sv
module sea_irq #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] event_v,
  input  logic [NCH-1:0] irq_en,
  input  logic           irq_rd,
  output logic [NCH-1:0] irq_sts
);
  for (genvar k = 0; k < NCH; k++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)                         irq_sts[k] <= 1'b0;
      else if (event_v[k] && irq_en[k]) irq_sts[k] <= 1'b1;
      else if (irq_rd)                 irq_sts[k] <= 1'b0;
    end
  end
endmodule

// File: rtl/sonet_err_accum.sv
module sonet_err_accum
  import sea_pkg::*;
#(
  parameter int LINE_BYTES = 3,
  parameter int SEC_W      = 16,
  parameter int LINE_W     = 20,
  parameter int PATH_W     = 16,
  parameter int FEBE_W     = 20,
  parameter int XFER_LAT   = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    frm_valid,
  input  logic                    blk_mode,
  input  logic                    three_ch,
  input  logic [7:0]              sec_rx,
  input  logic [7:0]              sec_calc,
  input  logic [8*LINE_BYTES-1:0] line_rx,
  input  logic [8*LINE_BYTES-1:0] line_calc,
  input  logic [7:0]              path_rx,
  input  logic [7:0]              path_calc,
  input  logic [3:0]              febe_fld,
  input  logic                    snap_wr,
  input  logic                    snap_all,
  input  logic [3:0]              irq_en,
  input  logic                    irq_rd,
  output logic [SEC_W-1:0]        hold_sec,
  output logic [LINE_W-1:0]       hold_line,
  output logic [PATH_W-1:0]       hold_path,
  output logic [FEBE_W-1:0]       hold_febe,
  output logic                    busy,
  output logic [3:0]              irq_sts
);
  logic [INC_W-1:0] inc_sec, inc_line, inc_path, inc_febe;
  logic take, publish;
  logic [3:0] ev;

  sea_event_calc #(.LINE_BYTES(LINE_BYTES)) u_calc (
    .frm_valid(frm_valid), .blk_mode(blk_mode), .three_ch(three_ch),
    .sec_rx(sec_rx), .sec_calc(sec_calc), .line_rx(line_rx), .line_calc(line_calc),
    .path_rx(path_rx), .path_calc(path_calc), .febe_fld(febe_fld),
    .inc_sec(inc_sec), .inc_line(inc_line), .inc_path(inc_path), .inc_febe(inc_febe)
  );

  sea_xfer_ctrl #(.XFER_LAT(XFER_LAT)) u_xfer (
    .clk(clk), .rst(rst), .req(snap_wr | snap_all),
    .take(take), .publish(publish), .busy(busy)
  );

  sea_accum #(.CNT_W(SEC_W)) u_sec (
    .clk(clk), .rst(rst), .inc(inc_sec), .take(take), .publish(publish), .hold_q(hold_sec));
  sea_accum #(.CNT_W(LINE_W)) u_line (
    .clk(clk), .rst(rst), .inc(inc_line), .take(take), .publish(publish), .hold_q(hold_line));
  sea_accum #(.CNT_W(PATH_W)) u_path (
    .clk(clk), .rst(rst), .inc(inc_path), .take(take), .publish(publish), .hold_q(hold_path));
  sea_accum #(.CNT_W(FEBE_W)) u_febe (
    .clk(clk), .rst(rst), .inc(inc_febe), .take(take), .publish(publish), .hold_q(hold_febe));

  assign ev[CH_SEC]  = |inc_sec;
  assign ev[CH_LINE] = |inc_line;
  assign ev[CH_PATH] = |inc_path;
  assign ev[CH_FEBE] = |inc_febe;

  sea_irq #(.NCH(4)) u_irq (
    .clk(clk), .rst(rst), .event_v(ev), .irq_en(irq_en), .irq_rd(irq_rd), .irq_sts(irq_sts));
endmodule

// File: rtl/sea_checker.sv
module sea_checker #(
  parameter int SEC_W  = 16,
  parameter int LINE_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              frm_valid,
  input logic              snap_wr,
  input logic              snap_all,
  input logic [3:0]        irq_en,
  input logic              irq_rd,
  input logic              busy,
  input logic [SEC_W-1:0]  hold_sec,
  input logic [LINE_W-1:0] hold_line,
  input logic [3:0]        irq_sts
);
  assert_busy_cause_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(snap_wr || snap_all));

  assert_snap_accept_R5: assert property (@(posedge clk) disable iff (rst)
    ((snap_wr || snap_all) && !busy) |=> busy);

  assert_hold_sec_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !$fell(busy) |-> $stable(hold_sec));

  assert_hold_line_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !$fell(busy) |-> $stable(hold_line));

  assert_irq_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (irq_rd && !frm_valid) |=> (irq_sts == 4'd0));

  for (genvar k = 0; k < 4; k++) begin : g_irq_chk
    assert_irq_gated_R9: assert property (@(posedge clk) disable iff (rst)
      $rose(irq_sts[k]) |-> $past(frm_valid && irq_en[k]));
  end
endmodule

bind sonet_err_accum sea_checker #(.SEC_W(SEC_W), .LINE_W(LINE_W)) u_sea_chk (
  .clk(clk), .rst(rst), .frm_valid(frm_valid), .snap_wr(snap_wr), .snap_all(snap_all),
  .irq_en(irq_en), .irq_rd(irq_rd), .busy(busy), .hold_sec(hold_sec),
  .hold_line(hold_line), .irq_sts(irq_sts)
);

// File: tb/test_sonet_err_accum.sv
module test_sonet_err_accum;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frm_valid = 0, blk_mode = 0, three_ch = 1;
  logic [7:0] sec_rx = 0, sec_calc = 0, path_rx = 0, path_calc = 0;
  logic [23:0] line_rx = 0, line_calc = 0;
  logic [3:0] febe_fld = 0;
  logic snap_wr = 0, snap_all = 0, irq_rd = 0;
  logic [3:0] irq_en = 4'hF;
  logic [15:0] hold_sec, hold_path;
  logic [19:0] hold_line, hold_febe;
  logic busy;
  logic [3:0] irq_sts;

  int checks = 0, fails = 0, cyc = 0;

  sonet_err_accum i_sonet_err_accum (
    .clk(clk), .rst(rst), .frm_valid(frm_valid), .blk_mode(blk_mode), .three_ch(three_ch),
    .sec_rx(sec_rx), .sec_calc(sec_calc), .line_rx(line_rx), .line_calc(line_calc),
    .path_rx(path_rx), .path_calc(path_calc), .febe_fld(febe_fld),
    .snap_wr(snap_wr), .snap_all(snap_all), .irq_en(irq_en), .irq_rd(irq_rd),
    .hold_sec(hold_sec), .hold_line(hold_line), .hold_path(hold_path), .hold_febe(hold_febe),
    .busy(busy), .irq_sts(irq_sts)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  longint m_cnt[4], m_stage[4], m_hold[4];
  longint m_max[4] = '{65535, 1048575, 65535, 1048575};
  int m_left = 0;
  bit [3:0] m_irq = 0;

  function automatic longint ev_amount(int ch);
    logic [23:0] d;
    if (!frm_valid) return 0;
    case (ch)
      0: d = {16'd0, sec_rx ^ sec_calc};
      1: d = (line_rx ^ line_calc) & (three_ch ? 24'hFFFFFF : 24'h0000FF);
      2: d = {16'd0, path_rx ^ path_calc};
      default: return (febe_fld <= 8) ? febe_fld : 0;
    endcase
    if (blk_mode) return (d != 0) ? 1 : 0;
    return $countones(d);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) begin m_cnt[i] = 0; m_stage[i] = 0; m_hold[i] = 0; end
      m_left = 0;
      m_irq = 0;
    end else begin
      bit acc;
      longint a[4];
      for (int i = 0; i < 4; i++) a[i] = ev_amount(i);
      acc = (snap_wr || snap_all) && (m_left == 0);
      if (m_left == 1) for (int i = 0; i < 4; i++) m_hold[i] = m_stage[i];
      if (m_left > 0) m_left--;
      for (int i = 0; i < 4; i++) begin
        if (acc) begin m_stage[i] = m_cnt[i]; m_cnt[i] = 0; end
        m_cnt[i] = m_cnt[i] + a[i];
        if (m_cnt[i] > m_max[i]) m_cnt[i] = m_max[i];
      end
      if (acc) m_left = LAT;
      for (int i = 0; i < 4; i++) begin
        if (a[i] != 0 && irq_en[i]) m_irq[i] = 1;
        else if (irq_rd) m_irq[i] = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(hold_sec == m_hold[0], "R1 hold_sec vs model", hold_sec, m_hold[0]);
      chk(hold_line == m_hold[1], "R3 hold_line vs model", hold_line, m_hold[1]);
      chk(hold_path == m_hold[2], "R1 hold_path vs model", hold_path, m_hold[2]);
      chk(hold_febe == m_hold[3], "R4 hold_febe vs model", hold_febe, m_hold[3]);
      chk(busy == (m_left != 0), "R6 busy vs model", busy, m_left != 0);
      chk(irq_sts == m_irq, "R9 irq_sts vs model", irq_sts, m_irq);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic set_frame(input logic [7:0] s, input logic [23:0] l, input logic [7:0] p,
                           input logic [3:0] f);
    frm_valid = 1; sec_rx = s; sec_calc = 0; line_rx = l; line_calc = 0;
    path_rx = p; path_calc = 0; febe_fld = f;
  endtask

  task automatic clr_frame(); frm_valid = 0; endtask

  task automatic frame(input logic [7:0] s, input logic [23:0] l, input logic [7:0] p,
                       input logic [3:0] f);
    set_frame(s, l, p, f); tick(); clr_frame();
  endtask

  task automatic snap_publish();
    snap_wr = 1; tick(); snap_wr = 0;
    repeat (LAT) tick();
  endtask

  initial begin
    repeat (3) tick();
    rst = 0;
    // R11 reset state
    chk(hold_sec == 0 && hold_line == 0 && hold_path == 0 && hold_febe == 0,
        "R11 holds zero", hold_sec + hold_line, 0);
    chk(busy == 0 && irq_sts == 0, "R11 busy irq zero", {busy, irq_sts}, 0);

    // R1 R3 R4 bit mode, three channels
    frame(8'h0F, 24'hFFFFFF, 8'hFE, 4'd8);
    snap_publish();
    chk(hold_sec == 4, "R1 section bit count", hold_sec, 4);
    chk(hold_path == 7, "R1 path bit count", hold_path, 7);
    chk(hold_line == 24, "R3 line three bytes", hold_line, 24);
    chk(hold_febe == 8, "R4 field 8 counted", hold_febe, 8);

    // R2 block mode
    blk_mode = 1;
    frame(8'h0F, 24'hFFFFFF, 8'hFE, 4'd3);
    frame(8'h80, 24'h010000, 8'h00, 4'd3);
    blk_mode = 0;
    snap_publish();
    chk(hold_sec == 2, "R2 section block count", hold_sec, 2);
    chk(hold_line == 2, "R2 line block count", hold_line, 2);
    chk(hold_path == 1, "R2 path block count", hold_path, 1);
    chk(hold_febe == 6, "R4 field 3 twice", hold_febe, 6);

    // R3 single channel, R4 illegal fields
    three_ch = 0;
    frame(8'h00, 24'hFF0001, 8'h00, 4'd9);
    frame(8'h00, 24'h00FF00, 8'h00, 4'd15);
    three_ch = 1;
    snap_publish();
    chk(hold_line == 1, "R3 upper bytes ignored", hold_line, 1);
    chk(hold_febe == 0, "R4 fields 9 and 15 add zero", hold_febe, 0);

    // R5 same-cycle event goes to new period; global strobe
    frame(8'h01, 24'h0, 8'h00, 4'd0);
    set_frame(8'h03, 24'h0, 8'h00, 4'd0); snap_all = 1; tick(); snap_all = 0; clr_frame();
    chk(busy == 1, "R6 busy after accept", busy, 1);
    chk(hold_sec == 0, "R6 hold not yet updated", hold_sec, 0);
    repeat (LAT) tick();
    chk(hold_sec == 1, "R5 old period published", hold_sec, 1);
    snap_publish();
    chk(hold_sec == 2, "R5 same-cycle event in new period", hold_sec, 2);

    // R7 request during busy ignored
    frame(8'h01, 24'h0, 8'h00, 4'd0);
    snap_wr = 1; tick(); snap_wr = 0;
    frame(8'h07, 24'h0, 8'h00, 4'd0);
    snap_wr = 1; tick(); snap_wr = 0;
    tick();
    chk(hold_sec == 1 && busy == 0, "R7 second request ignored", hold_sec, 1);
    snap_publish();
    chk(hold_sec == 3, "R7 count kept across ignored request", hold_sec, 3);

    // R9 R10 interrupts
    irq_rd = 1; tick(); irq_rd = 0;
    irq_en = 4'h0;
    frame(8'h01, 24'h0, 8'h00, 4'd0);
    chk(irq_sts == 0, "R9 disabled flag stays low", irq_sts, 0);
    irq_en = 4'hF;
    frame(8'h01, 24'h0, 8'h01, 4'd0);
    chk(irq_sts == 4'b0101, "R9 flags set", irq_sts, 5);
    irq_rd = 1; set_frame(8'h00, 24'h000001, 8'h00, 4'd0); tick(); irq_rd = 0; clr_frame();
    chk(irq_sts == 4'b0010, "R10 clear with set winning", irq_sts, 2);
    irq_rd = 1; tick(); irq_rd = 0;
    chk(irq_sts == 0, "R10 cleared on read", irq_sts, 0);

    // R8 saturation
    snap_publish();
    for (int i = 0; i < 8200; i++) frame(8'hFF, 24'h0, 8'h00, 4'd0);
    snap_publish();
    chk(hold_sec == 16'hFFFF, "R8 section saturates", hold_sec, 65535);

    repeat (4) tick();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule